// File: doc/BRIEF.md
# Virtual Address Region Checker

This block sits between a processor's load/store and fetch paths and its translation lookaside buffer. It takes one 32-bit access at a time, together with the access kind and the privilege level. It then decides whether the address goes straight to memory, goes through the TLB, or faults at once. Translated accesses are sent to an external TLB port. That port replies with hit, a frame number and read/write/execute permission bits. The block then builds the physical address or picks a fault code.

When a fault occurs, the block captures the information a refill or fault handler needs. It holds the faulting address, a page-table-entry pointer and a flag that tells data accesses from instruction fetches. The page-table base field of that pointer is loaded by the surrounding logic and is otherwise left alone. A parameter removes translation entirely. In that case every address passes through unchanged.

Top module: `vaddr_region_chk`

## Requirements
- R1: In supervisor mode (`req_super`=1), an address at or above 0xC000_0000 completes without a TLB lookup, with `phys_addr` equal to the request address and no fault.
- R2: A supervisor address below 0xC000_0000, or a user address below 0x8000_0000, raises `tlb_req` with `tlb_vpn` equal to address bits 31:12.
- R3: A user access at or above 0x8000_0000 completes without a TLB lookup, with fault code 9 and `badaddr_q` set to the full address. `pteaddr_q` and `tlbmisc_data_q` are left unchanged.
- R4: Access kind encoding is 00 read, 01 write, 10 fetch (11 is handled as a fetch). On a TLB hit, a read without read permission faults with code 13, a write without write permission with code 14, and a fetch without execute permission with code 15.
- R5: A TLB lookup that misses faults with code 12.
- R6: A successful translated access returns `{tlb_frame, address[11:0]}` (4 KB pages).
- R7: On a translation fault (codes 12 to 15), `pteaddr_q[21:2]` takes address bits 31:12 and `pteaddr_q[1:0]` is zero. `pteaddr_q[31:22]` keeps the base last written through `pt_base_wr`/`pt_base_val`, and `badaddr_q` takes the full address.
- R8: On a translation fault, `tlbmisc_data_q` is set to 1 for reads and writes and cleared to 0 for fetches.
- R9: With `MMU_EN`=0, every access completes one cycle after acceptance with `phys_addr` equal to the address, no fault and no TLB lookup.
- R10: A request is accepted when the block is idle. A direct access (bypass or address fault) pulses `done` for one cycle, in the cycle after acceptance. A translated access holds `tlb_req` until `tlb_rsp_valid` is seen, and pulses `done` in the cycle after that.
- R11: A completion without fault shows `fault`=0 and `fault_code`=0, and leaves `badaddr_q`, `pteaddr_q` and `tlbmisc_data_q` unchanged.
- R12: After reset, `done`, `tlb_req`, `badaddr_q`, `pteaddr_q` and `tlbmisc_data_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| pt_base_wr | input | 1 | Load the page-table base field |
| pt_base_val | input | 10 | New page-table base (pointer bits 31:22) |
| tlb_req | output | 1 | TLB lookup pending |
| tlb_vpn | output | 20 | Virtual page number to look up |
| tlb_rsp_valid | input | 1 | TLB reply valid |
| tlb_hit | input | 1 | TLB entry found |
| tlb_frame | input | 20 | Physical frame number |
| tlb_perm_r | input | 1 | Read allowed |
| tlb_perm_w | input | 1 | Write allowed |
| tlb_perm_x | input | 1 | Execute allowed |
| done | output | 1 | One-cycle completion pulse |
| phys_addr | output | 32 | Physical address (valid with `done`, no fault) |
| fault | output | 1 | Completion is a fault |
| fault_code | output | 5 | Fault cause, 0 when no fault |
| badaddr_q | output | 32 | Last faulting address |
| pteaddr_q | output | 32 | Page-table-entry pointer: base, VPN, 00 |
| tlbmisc_data_q | output | 1 | Last translation fault was a data access |

## Verification
The hardest case to reach is a chain of faults whose captured state must survive later events. A supervisor-only fault must leave the page-table pointer and data flag from an earlier translation fault untouched. A later successful access must leave all three capture registers alone. The bench therefore runs a translation fault, then an address fault, then a clean access, and checks the capture outputs after each one. A behavioural TLB responder delays some replies by several cycles to show that the lookup request is held. A second instance built without translation receives the same stimulus.

// File: rtl/vrc_pkg.sv
// Shared types and fault codes for the virtual address region checker.
package vrc_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_t;

    typedef enum logic [1:0] {
        RG_BYPASS = 2'b00,
        RG_XLATE  = 2'b01,
        RG_DENY   = 2'b10
    } region_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_t;

    localparam logic [4:0] FC_NONE       = 5'd0;
    localparam logic [4:0] FC_SUPER_ONLY = 5'd9;
    localparam logic [4:0] FC_TLB_MISS   = 5'd12;
    localparam logic [4:0] FC_NO_READ    = 5'd13;
    localparam logic [4:0] FC_NO_WRITE   = 5'd14;
    localparam logic [4:0] FC_NO_EXEC    = 5'd15;
endpackage

// File: rtl/vrc_region_dec.sv
// Region decoder: maps address and privilege onto bypass, translate or deny.
// Assumes the address windows are fixed by parameters; purely combinational.
module vrc_region_dec #(
    parameter int          ADDR_W      = 32,
    parameter bit          MMU_EN      = 1'b1,
    parameter logic [31:0] BYPASS_BASE = 32'hC000_0000,
    parameter logic [31:0] USER_TOP    = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              super_mode,
    output vrc_pkg::region_t  region
);
    import vrc_pkg::*;

    generate
        if (MMU_EN) begin : g_mmu
            // Pick the window from privilege and address.
            always_comb begin
                if (super_mode)
                    region = (addr >= BYPASS_BASE[ADDR_W-1:0]) ? RG_BYPASS : RG_XLATE;
                else
                    region = (addr >= USER_TOP[ADDR_W-1:0]) ? RG_DENY : RG_XLATE;
            end
        end else begin : g_flat
            // Without translation everything bypasses.
            assign region = RG_BYPASS;
        end
    endgenerate
endmodule

// File: rtl/vrc_perm_chk.sv
// Permission checker: turns a TLB reply and access kind into a fault code.
// Assumes kind 11 behaves as an instruction fetch; purely combinational.
module vrc_perm_chk (
    input  logic [1:0] kind,
    input  logic       hit,
    input  logic       perm_r,
    input  logic       perm_w,
    input  logic       perm_x,
    output logic       bad,
    output logic [4:0] code
);
    import vrc_pkg::*;

    // Select the permission the access needs and derive the cause.
    always_comb begin
        bad  = 1'b0;
        code = FC_NONE;
        if (!hit) begin
            bad  = 1'b1;
            code = FC_TLB_MISS;
        end else begin
            case (kind)
                ACC_READ:  if (!perm_r) begin bad = 1'b1; code = FC_NO_READ;  end
                ACC_WRITE: if (!perm_w) begin bad = 1'b1; code = FC_NO_WRITE; end
                default:   if (!perm_x) begin bad = 1'b1; code = FC_NO_EXEC;  end
            endcase
        end
    end
endmodule

// File: rtl/vrc_fault_regs.sv
// Fault capture registers: bad address, page-table-entry pointer and the
// data/fetch flag. Assumes log strobes are single-cycle from the control FSM.
module vrc_fault_regs #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = ADDR_W - PAGE_BITS,
    localparam int BASE_W   = ADDR_W - VPN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_val,
    input  logic              log_bad,
    input  logic              log_xlate,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_data,
    output logic [ADDR_W-1:0] badaddr_q,
    output logic [ADDR_W-1:0] pteaddr_q,
    output logic              misc_data_q
);
    logic [BASE_W-1:0] base_q;
    logic [VPN_W-1:0]  vpn_q;

    // Bad-address capture on any fault.
    always_ff @(posedge clk) begin
        if (!rst_n)       badaddr_q <= '0;
        else if (log_bad) badaddr_q <= addr;
    end

    // Page-table base field, written only by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= base_val;
    end

    // VPN field and data flag, loaded on translation faults only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q       <= '0;
            misc_data_q <= 1'b0;
        end else if (log_xlate) begin
            vpn_q       <= addr[ADDR_W-1:PAGE_BITS];
            misc_data_q <= is_data;
        end
    end

    assign pteaddr_q = {base_q, vpn_q, 2'b00};

    // Base field moves only when written.
    assert_base_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> (pteaddr_q[ADDR_W-1:ADDR_W-BASE_W] == $past(pteaddr_q[ADDR_W-1:ADDR_W-BASE_W])));
    // Capture registers hold while no fault is logged.
    assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_bad && !log_xlate) |=> (badaddr_q == $past(badaddr_q)) && (misc_data_q == $past(misc_data_q)));
endmodule

// File: rtl/vaddr_region_chk.sv
// Virtual address region checker top: accepts one access while idle, decodes
// its region, runs a TLB lookup when needed and reports a one-cycle result.
// Assumes the requester waits for done before issuing the next access.
module vaddr_region_chk #(
    parameter int          ADDR_W      = 32,
    parameter int          PAGE_BITS   = 12,
    parameter bit          MMU_EN      = 1'b1,
    parameter logic [31:0] BYPASS_BASE = 32'hC000_0000,
    parameter logic [31:0] USER_TOP    = 32'h8000_0000,
    localparam int         VPN_W       = ADDR_W - PAGE_BITS,
    localparam int         BASE_W      = ADDR_W - VPN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    input  logic              pt_base_wr,
    input  logic [BASE_W-1:0] pt_base_val,
    output logic              tlb_req,
    output logic [VPN_W-1:0]  tlb_vpn,
    input  logic              tlb_rsp_valid,
    input  logic              tlb_hit,
    input  logic [VPN_W-1:0]  tlb_frame,
    input  logic              tlb_perm_r,
    input  logic              tlb_perm_w,
    input  logic              tlb_perm_x,
    output logic              done,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              fault,
    output logic [4:0]        fault_code,
    output logic [ADDR_W-1:0] badaddr_q,
    output logic [ADDR_W-1:0] pteaddr_q,
    output logic              tlbmisc_data_q
);
    import vrc_pkg::*;

    state_t            state_q;
    region_t           region;
    logic [ADDR_W-1:0] cap_addr;
    logic [1:0]        cap_kind;
    logic              perm_bad;
    logic [4:0]        perm_code;
    logic              accept, finish;
    logic              log_bad, log_xlate;
    logic [ADDR_W-1:0] log_addr;

    vrc_region_dec #(
        .ADDR_W(ADDR_W), .MMU_EN(MMU_EN),
        .BYPASS_BASE(BYPASS_BASE), .USER_TOP(USER_TOP)
    ) u_dec (
        .addr(req_addr), .super_mode(req_super), .region(region)
    );

    vrc_perm_chk u_perm (
        .kind(cap_kind), .hit(tlb_hit),
        .perm_r(tlb_perm_r), .perm_w(tlb_perm_w), .perm_x(tlb_perm_x),
        .bad(perm_bad), .code(perm_code)
    );

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign finish    = (state_q == ST_WAIT) && tlb_rsp_valid;
    assign log_xlate = finish && perm_bad;
    assign log_bad   = log_xlate || (accept && region == RG_DENY);
    assign log_addr  = (state_q == ST_IDLE) ? req_addr : cap_addr;

    vrc_fault_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .base_wr(pt_base_wr), .base_val(pt_base_val),
        .log_bad(log_bad), .log_xlate(log_xlate),
        .addr(log_addr), .is_data(cap_kind != ACC_FETCH && cap_kind != 2'b11),
        .badaddr_q(badaddr_q), .pteaddr_q(pteaddr_q), .misc_data_q(tlbmisc_data_q)
    );

    assign tlb_req = (state_q == ST_WAIT);
    assign tlb_vpn = cap_addr[ADDR_W-1:PAGE_BITS];

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_kind <= ACC_READ;
        end else if (accept) begin
            cap_addr <= req_addr;
            cap_kind <= req_kind;
        end
    end

    // Control FSM and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            done       <= 1'b0;
            phys_addr  <= '0;
            fault      <= 1'b0;
            fault_code <= FC_NONE;
        end else begin
            done <= 1'b0;
            if (accept) begin
                case (region)
                    RG_BYPASS: begin
                        done <= 1'b1; fault <= 1'b0;
                        fault_code <= FC_NONE; phys_addr <= req_addr;
                    end
                    RG_DENY: begin
                        done <= 1'b1; fault <= 1'b1;
                        fault_code <= FC_SUPER_ONLY; phys_addr <= '0;
                    end
                    default: state_q <= ST_WAIT;
                endcase
            end else if (finish) begin
                state_q    <= ST_IDLE;
                done       <= 1'b1;
                fault      <= perm_bad;
                fault_code <= perm_code;
                phys_addr  <= perm_bad ? '0 : {tlb_frame, cap_addr[PAGE_BITS-1:0]};
            end
        end
    end

    // Bypass window returns the address untouched.
    assert_bypass_ident_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && MMU_EN && cap_addr >= BYPASS_BASE[ADDR_W-1:0] && $past(req_super) && !$past(tlb_req))
        |-> (phys_addr == cap_addr) && !fault);
    // Supervisor-only fault logs the full address.
    assert_deny_logged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_code == FC_SUPER_ONLY) |-> badaddr_q == cap_addr);
    // Translation fault fills the VPN field of the pointer.
    assert_pte_vpn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_code >= FC_TLB_MISS)
        |-> (pteaddr_q[VPN_W+1:2] == cap_addr[ADDR_W-1:PAGE_BITS]) && (badaddr_q == cap_addr));
    // Lookup stays raised until answered.
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && !tlb_rsp_valid) |=> tlb_req && !done);
    // Clean completions carry code zero.
    assert_clean_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> fault_code == FC_NONE);
endmodule

// File: tb/tb_vaddr_region_chk.sv
module tb_vaddr_region_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        pt_base_wr = 1'b0;
    logic [9:0]  pt_base_val = '0;
    logic        tlb_rsp_valid = 1'b0, tlb_hit = 1'b0;
    logic [19:0] tlb_frame = '0;
    logic        tlb_perm_r = 1'b0, tlb_perm_w = 1'b0, tlb_perm_x = 1'b0;

    logic        tlb_req, done, fault, misc;
    logic [19:0] tlb_vpn;
    logic [31:0] phys, badaddr, pteaddr;
    logic [4:0]  code;
    logic        f_tlb_req, f_done, f_fault, f_misc;
    logic [19:0] f_vpn;
    logic [31:0] f_phys, f_bad, f_pte;
    logic [4:0]  f_code;

    int checks = 0;
    int fails  = 0;
    logic [9:0] exp_base = '0;

    always #2 clk = ~clk;

    vaddr_region_chk dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_super(req_super), .pt_base_wr(pt_base_wr),
        .pt_base_val(pt_base_val), .tlb_req(tlb_req), .tlb_vpn(tlb_vpn),
        .tlb_rsp_valid(tlb_rsp_valid), .tlb_hit(tlb_hit), .tlb_frame(tlb_frame),
        .tlb_perm_r(tlb_perm_r), .tlb_perm_w(tlb_perm_w), .tlb_perm_x(tlb_perm_x),
        .done(done), .phys_addr(phys), .fault(fault), .fault_code(code),
        .badaddr_q(badaddr), .pteaddr_q(pteaddr), .tlbmisc_data_q(misc));

    vaddr_region_chk #(.MMU_EN(1'b0)) dut_flat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_super(req_super), .pt_base_wr(pt_base_wr),
        .pt_base_val(pt_base_val), .tlb_req(f_tlb_req), .tlb_vpn(f_vpn),
        .tlb_rsp_valid(tlb_rsp_valid), .tlb_hit(tlb_hit), .tlb_frame(tlb_frame),
        .tlb_perm_r(tlb_perm_r), .tlb_perm_w(tlb_perm_w), .tlb_perm_x(tlb_perm_x),
        .done(f_done), .phys_addr(f_phys), .fault(f_fault), .fault_code(f_code),
        .badaddr_q(f_bad), .pteaddr_q(f_pte), .tlbmisc_data_q(f_misc));

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One access with a behavioural TLB reply; checks handshake timing (R10),
    // lookup (R2) and the flat instance (R9). Results sampled at done.
    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic s,
                          input logic lookup, input logic hit, input logic [19:0] frm,
                          input logic [2:0] rwx, input int delay,
                          output logic [31:0] o_phys, output logic o_fault,
                          output logic [4:0] o_code);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_super = s;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "flat done", {31'd0, f_done}, 32'd1);
        check("R9", "flat phys", f_phys, a);
        check("R9", "flat fault", {31'd0, f_fault | f_tlb_req}, 32'd0);
        if (lookup) begin
            check("R2", "tlb_req raised", {31'd0, tlb_req}, 32'd1);
            check("R2", "tlb_vpn", {12'd0, tlb_vpn}, {12'd0, a[31:12]});
            check("R10", "no early done", {31'd0, done}, 32'd0);
            for (int i = 0; i < delay; i++) begin
                @(negedge clk);
                check("R10", "tlb_req held", {31'd0, tlb_req & ~done}, 32'd1);
            end
            tlb_rsp_valid = 1'b1; tlb_hit = hit; tlb_frame = frm;
            {tlb_perm_r, tlb_perm_w, tlb_perm_x} = rwx;
            @(negedge clk);
            tlb_rsp_valid = 1'b0;
            check("R10", "done after reply", {31'd0, done}, 32'd1);
            check("R10", "tlb_req dropped", {31'd0, tlb_req}, 32'd0);
        end else begin
            check("R10", "direct done", {31'd0, done}, 32'd1);
            check("R1", "no lookup on direct path", {31'd0, tlb_req}, 32'd0);
        end
        o_phys = phys; o_fault = fault; o_code = code;
        @(negedge clk);
        check("R10", "done is one pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        check("R12", "done", {31'd0, done}, 32'd0);
        check("R12", "tlb_req", {31'd0, tlb_req}, 32'd0);
        check("R12", "badaddr", badaddr, 32'd0);
        check("R12", "pteaddr", pteaddr, 32'd0);
        check("R12", "misc", {31'd0, misc}, 32'd0);
    endtask

    task automatic t_base();
        @(negedge clk);
        pt_base_wr = 1'b1; pt_base_val = 10'h2A5; exp_base = 10'h2A5;
        @(negedge clk);
        pt_base_wr = 1'b0;
        check("R7", "base loaded", pteaddr, {10'h2A5, 22'd0});
    endtask

    task automatic t_bypass();
        logic [31:0] p; logic f; logic [4:0] c;
        access(32'hC000_1234, 2'b00, 1'b1, 1'b0, 1'b0, 20'h0, 3'b000, 0, p, f, c);
        check("R1", "bypass phys low edge", p, 32'hC000_1234);
        check("R1", "bypass no fault", {31'd0, f}, 32'd0);
        access(32'hFFFF_FFFF, 2'b10, 1'b1, 1'b0, 1'b0, 20'h0, 3'b000, 0, p, f, c);
        check("R1", "bypass phys top", p, 32'hFFFF_FFFF);
        check("R11", "bypass code", {27'd0, c}, 32'd0);
    endtask

    task automatic t_translate();
        logic [31:0] p; logic f; logic [4:0] c;
        access(32'h8000_5678, 2'b00, 1'b1, 1'b1, 1'b1, 20'h12345, 3'b100, 0, p, f, c);
        check("R6", "super read phys", p, 32'h1234_5678);
        check("R11", "clean fault flag", {31'd0, f}, 32'd0);
        access(32'hBFFF_FFFF, 2'b10, 1'b1, 1'b1, 1'b1, 20'hABCDE, 3'b001, 1, p, f, c);
        check("R6", "super fetch below bypass", p, 32'hABCD_EFFF);
        access(32'h7FFF_F004, 2'b01, 1'b0, 1'b1, 1'b1, 20'h00042, 3'b010, 3, p, f, c);
        check("R6", "user write phys", p, 32'h0004_2004);
        check("R11", "clean code", {27'd0, c}, 32'd0);
    endtask

    task automatic t_perm();
        logic [31:0] p; logic f; logic [4:0] c;
        access(32'h1234_5ABC, 2'b00, 1'b0, 1'b1, 1'b1, 20'h1, 3'b011, 0, p, f, c);
        check("R4", "read denied code", {27'd0, c}, 32'd13);
        check("R7", "pte after read fault", pteaddr, {exp_base, 20'h12345, 2'b00});
        check("R7", "badaddr read fault", badaddr, 32'h1234_5ABC);
        check("R8", "data flag on read", {31'd0, misc}, 32'd1);
        access(32'h0000_3010, 2'b10, 1'b1, 1'b1, 1'b1, 20'h1, 3'b110, 2, p, f, c);
        check("R4", "fetch denied code", {27'd0, c}, 32'd15);
        check("R8", "data flag cleared on fetch", {31'd0, misc}, 32'd0);
        access(32'h4567_8000, 2'b01, 1'b0, 1'b1, 1'b1, 20'h1, 3'b101, 0, p, f, c);
        check("R4", "write denied code", {27'd0, c}, 32'd14);
        check("R4", "write denied flag", {31'd0, f}, 32'd1);
        check("R8", "data flag on write", {31'd0, misc}, 32'd1);
        access(32'h4567_8000, 2'b01, 1'b0, 1'b1, 1'b1, 20'h00777, 3'b010, 0, p, f, c);
        check("R4", "write allowed", p, 32'h0077_7000);
    endtask

    task automatic t_miss_then_deny();
        logic [31:0] p; logic f; logic [4:0] c;
        access(32'h9ABC_DEF0, 2'b10, 1'b1, 1'b1, 1'b0, 20'h0, 3'b111, 1, p, f, c);
        check("R5", "miss code", {27'd0, c}, 32'd12);
        check("R7", "pte after miss", pteaddr, {exp_base, 20'h9ABCD, 2'b00});
        check("R8", "fetch miss flag", {31'd0, misc}, 32'd0);
        access(32'h8000_0000, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 3'b000, 0, p, f, c);
        check("R3", "deny code", {27'd0, c}, 32'd9);
        check("R3", "deny badaddr", badaddr, 32'h8000_0000);
        check("R3", "deny keeps pte", pteaddr, {exp_base, 20'h9ABCD, 2'b00});
        check("R3", "deny keeps flag", {31'd0, misc}, 32'd0);
        access(32'h0000_1FFC, 2'b00, 1'b0, 1'b1, 1'b1, 20'h00055, 3'b100, 0, p, f, c);
        check("R11", "clean keeps badaddr", badaddr, 32'h8000_0000);
        check("R11", "clean keeps pte", pteaddr, {exp_base, 20'h9ABCD, 2'b00});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base();
        t_bypass();
        t_translate();
        t_perm();
        t_miss_then_deny();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule